// File: doc/BRIEF.md
# Bus Access Protection Checker

This block sits beside a bus fabric and decides, for every access, whether the requesting master may touch the addressed location. It keeps a bank of programmable address windows. Each window has a first and last 32-byte page, a valid bit, an optional process-identifier qualifier, and a permission nibble for every bus master. Several access ports are looked up in the same cycle. Every port compares its request against all windows in parallel and returns either a grant or a protection fault in that same cycle.

Windows may overlap, and an access goes through when any one window that covers it grants the requested right. Execute rights and supervisor-only restrictions are kept only for the processor masters. The other masters have read and write rights only. Software programs the windows through a word-indexed register port. When an access is denied, the block records the faulting address and the access attributes for that port in capture registers. A sticky per-port fault flag is raised, and software clears it by writing a one to its bit.

Top module: `mpu_guard`

## Requirements
- R1: After reset every window is invalid, every fault flag and capture register reads zero, and every valid access is denied.
- R2: A window covers an access when first_page <= addr[31:5] <= last_page, both ends inclusive. Writes to the first/last page words keep only bits [31:5], so bits [4:0] read back as zero.
- R3: Windows may overlap. An access is granted when at least one valid window that covers it grants the requested right, even if another covering window does not.
- R4: Access kind encoding is 0 read, 1 write, 2 execute, 3 reserved (always denied). Permission nibble bit 0 grants read and bit 1 grants write, for every master.
- R5: Masters with ID below NUM_CPU are processors. Nibble bit 2 grants execute, and nibble bit 3 set makes the window supervisor-only (user accesses denied). For other masters, bits 2 and 3 are not stored (they read back as zero), and execute is always denied.
- R6: When a window's PID-enable bit is set, it covers an access only if the access PID equals the window's stored PID. When the bit is clear, the PID is ignored.
- R7: An access that no valid window grants is denied: acc_err is high and acc_allow is low in the same cycle. Invalid windows take no part in the lookup.
- R8: Each access port is evaluated independently and at the same time as the others.
- R9: A denial on a port whose flag is clear sets the flag on the next edge. It also captures the full address and a detail word: [1:0] kind, [2] supervisor, [11:8] master, [23:16] PID.
- R10: While the flag is set, later denials do not overwrite the capture. Writing 1 to the flag bit clears it. A denial in the same cycle as that clear wins: the flag stays set and the new fault is captured.
- R11: With acc_valid low, a port shows neither grant nor fault and captures nothing.
- R12: Register map, by word index: window w uses 4w+0 first page, 4w+1 last page, 4w+2 permissions (master m in bits [4m+3:4m]), and 4w+3 control ([0] valid, [1] PID-enable, [15:8] PID). Next come two words per port p at 4*NUM_REGIONS+2p (address) and +2p+1 (detail). The last word holds the flags, bit p for port p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | CFG_AW | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | NUM_PORTS | Access present, one bit per port |
| acc_addr | input | NUM_PORTS*ADDR_W | Access byte address per port |
| acc_master | input | NUM_PORTS*MID_W | Requesting master ID per port |
| acc_kind | input | NUM_PORTS*2 | Access kind per port |
| acc_sup | input | NUM_PORTS | Supervisor mode per port |
| acc_pid | input | NUM_PORTS*PID_W | Process ID per port |
| acc_allow | output | NUM_PORTS | Access granted |
| acc_err | output | NUM_PORTS | Protection fault |

## Verification
The hardest case to reach from the ports is a new denial that arrives in the same cycle as the software write clearing that port's flag. The bench sets this up by holding a faulting access on a port while it writes a one to the flag word. It then reads the capture back to confirm the newer fault was recorded. Directed sequences also cover inclusive window edges, overlapping windows that split the rights, and three ports with different outcomes in one cycle. A random phase then mixes window rewrites, flag clears and accesses, and a behavioural model checks each cycle's verdicts.

// File: rtl/mpu_guard_pkg.sv
`timescale 1ns/1ps
package mpu_guard_pkg;

   localparam int unsigned GRAN_BITS = 5;
   localparam int unsigned CFG_DW    = 32;

   typedef enum logic [1:0] {
      KIND_RD  = 2'b00,
      KIND_WR  = 2'b01,
      KIND_EX  = 2'b10,
      KIND_RSV = 2'b11
   } acc_kind_e;

   // nibble: [0] read, [1] write, [2] execute, [3] supervisor-only
   function automatic logic perm_grants(input logic [3:0] nib,
                                        input logic [1:0] kind,
                                        input logic       sup,
                                        input logic       is_cpu);
      logic ok;
      case (acc_kind_e'(kind))
         KIND_RD: ok = nib[0];
         KIND_WR: ok = nib[1];
         KIND_EX: ok = is_cpu & nib[2];
         default: ok = 1'b0;
      endcase
      if (is_cpu && nib[3] && !sup) ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/mpu_guard_errlog.sv
`timescale 1ns/1ps
module mpu_guard_errlog #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MID_W  = 2,
   parameter int unsigned PID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              deny,
   input  logic              clr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [MID_W-1:0]  master,
   input  logic [1:0]        kind,
   input  logic              sup,
   input  logic [PID_W-1:0]  pid,
   output logic              flag,
   output logic [31:0]       rd_addr,
   output logic [31:0]       rd_detail
);

   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       det_q;
   logic [7:0]        pid8;
   logic [3:0]        mst4;

   assign pid8 = 8'(pid);
   assign mst4 = 4'(master);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         addr_q <= '0;
         det_q  <= '0;
      end else begin
         if (deny && (!flag || clr)) begin
            addr_q <= addr;
            det_q  <= {8'b0, pid8, 4'b0, mst4, 5'b0, sup, kind};
         end
         flag <= (flag & ~clr) | deny;
      end
   end

   assign rd_addr   = 32'(addr_q);
   assign rd_detail = det_q;

endmodule

// File: rtl/mpu_guard_region.sv
`timescale 1ns/1ps
module mpu_guard_region
   import mpu_guard_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 3,
   parameter int unsigned NUM_MASTERS = 4,
   parameter int unsigned NUM_CPU     = 2,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_W      = ADDR_W - GRAN_BITS,
   parameter int unsigned MID_W       = 2,
   parameter int unsigned PID_W       = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_start,
   input  logic                        wr_end,
   input  logic                        wr_perm,
   input  logic                        wr_ctrl,
   input  logic [CFG_DW-1:0]           wdata,
   input  logic [NUM_PORTS*PAGE_W-1:0] acc_page,
   input  logic [NUM_PORTS*MID_W-1:0]  acc_master,
   input  logic [NUM_PORTS*2-1:0]      acc_kind,
   input  logic [NUM_PORTS-1:0]        acc_sup,
   input  logic [NUM_PORTS*PID_W-1:0]  acc_pid,
   output logic [NUM_PORTS-1:0]        hit,
   output logic [CFG_DW-1:0]           rd_start,
   output logic [CFG_DW-1:0]           rd_end,
   output logic [CFG_DW-1:0]           rd_perm,
   output logic [CFG_DW-1:0]           rd_ctrl
);

   logic [PAGE_W-1:0] start_q, end_q;
   logic              valid_q, pid_en_q;
   logic [PID_W-1:0]  pid_q;
   logic [3:0]        perm_w [NUM_MASTERS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q  <= '0;
         end_q    <= '0;
         valid_q  <= 1'b0;
         pid_en_q <= 1'b0;
         pid_q    <= '0;
      end else begin
         if (wr_start) start_q <= wdata[ADDR_W-1:GRAN_BITS];
         if (wr_end)   end_q   <= wdata[ADDR_W-1:GRAN_BITS];
         if (wr_ctrl) begin
            valid_q  <= wdata[0];
            pid_en_q <= wdata[1];
            pid_q    <= wdata[8 +: PID_W];
         end
      end
   end

   // permission storage: processors keep all four bits, others only R/W
   for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
      logic [1:0] rw_q;
      always_ff @(posedge clk) begin
         if (!rst_n)       rw_q <= '0;
         else if (wr_perm) rw_q <= wdata[m*4 +: 2];
      end
      if (m < NUM_CPU) begin : g_cpu
         logic [1:0] xs_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       xs_q <= '0;
            else if (wr_perm) xs_q <= wdata[m*4+2 +: 2];
         end
         assign perm_w[m] = {xs_q, rw_q};
      end else begin : g_dev
         assign perm_w[m] = {2'b00, rw_q};
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PAGE_W-1:0] pg;
      logic [3:0]        nib;
      logic              is_cpu;
      logic              in_rng, pid_ok;

      assign pg = acc_page[p*PAGE_W +: PAGE_W];

      always_comb begin
         nib    = '0;
         is_cpu = 1'b0;
         for (int m = 0; m < NUM_MASTERS; m++) begin
            if (acc_master[p*MID_W +: MID_W] == MID_W'(m)) begin
               nib    = perm_w[m];
               is_cpu = (m < NUM_CPU);
            end
         end
      end

      assign in_rng = (pg >= start_q) && (pg <= end_q);
      assign pid_ok = !pid_en_q || (acc_pid[p*PID_W +: PID_W] == pid_q);
      assign hit[p] = valid_q && in_rng && pid_ok &&
                      perm_grants(nib, acc_kind[p*2 +: 2], acc_sup[p], is_cpu);
   end

   always_comb begin
      rd_perm = '0;
      for (int m = 0; m < NUM_MASTERS; m++) rd_perm[m*4 +: 4] = perm_w[m];
   end

   assign rd_start = CFG_DW'({start_q, {GRAN_BITS{1'b0}}});
   assign rd_end   = CFG_DW'({end_q,   {GRAN_BITS{1'b0}}});
   assign rd_ctrl  = {16'b0, 8'(pid_q), 6'b0, pid_en_q, valid_q};

endmodule

// File: rtl/mpu_guard.sv
`timescale 1ns/1ps
module mpu_guard
   import mpu_guard_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 8,
   parameter int unsigned NUM_PORTS   = 3,
   parameter int unsigned NUM_MASTERS = 4,
   parameter int unsigned NUM_CPU     = 2,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PID_W       = 8,
   localparam int unsigned MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
   localparam int unsigned REG_WORDS  = NUM_REGIONS * 4,
   localparam int unsigned ERR_BASE   = REG_WORDS,
   localparam int unsigned FLAG_IDX   = ERR_BASE + NUM_PORTS * 2,
   localparam int unsigned CFG_AW     = $clog2(FLAG_IDX + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [CFG_AW-1:0]           cfg_idx,
   input  logic [31:0]                 cfg_wdata,
   output logic [31:0]                 cfg_rdata,
   input  logic [NUM_PORTS-1:0]        acc_valid,
   input  logic [NUM_PORTS*ADDR_W-1:0] acc_addr,
   input  logic [NUM_PORTS*MID_W-1:0]  acc_master,
   input  logic [NUM_PORTS*2-1:0]      acc_kind,
   input  logic [NUM_PORTS-1:0]        acc_sup,
   input  logic [NUM_PORTS*PID_W-1:0]  acc_pid,
   output logic [NUM_PORTS-1:0]        acc_allow,
   output logic [NUM_PORTS-1:0]        acc_err
);

   localparam int unsigned PAGE_W = ADDR_W - GRAN_BITS;

   if (NUM_REGIONS < 1 || NUM_REGIONS > 16) begin : g_bad_regions
      $error("mpu_guard: NUM_REGIONS must lie in 1..16");
   end
   if (NUM_MASTERS < 1 || NUM_MASTERS > 8) begin : g_bad_masters
      $error("mpu_guard: NUM_MASTERS must lie in 1..8");
   end
   if (NUM_CPU > NUM_MASTERS) begin : g_bad_cpu
      $error("mpu_guard: NUM_CPU exceeds NUM_MASTERS");
   end
   if (PID_W < 1 || PID_W > 8) begin : g_bad_pid
      $error("mpu_guard: PID_W must lie in 1..8");
   end
   if (ADDR_W <= GRAN_BITS || ADDR_W > 32) begin : g_bad_addr
      $error("mpu_guard: ADDR_W must lie in 6..32");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > 8) begin : g_bad_ports
      $error("mpu_guard: NUM_PORTS must lie in 1..8");
   end

   logic [NUM_PORTS*PAGE_W-1:0] acc_page;
   logic [NUM_PORTS-1:0]        reg_hit [NUM_REGIONS];
   logic [NUM_REGIONS-1:0]      hit_col [NUM_PORTS];
   logic [31:0]                 reg_rd  [REG_WORDS];
   logic [31:0]                 err_rd_addr [NUM_PORTS];
   logic [31:0]                 err_rd_det  [NUM_PORTS];
   logic [NUM_PORTS-1:0]        err_flag;
   logic [NUM_PORTS*32-1:0]     cap_addr_flat;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_page
      assign acc_page[p*PAGE_W +: PAGE_W] = acc_addr[p*ADDR_W+GRAN_BITS +: PAGE_W];
   end

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
      mpu_guard_region #(
         .NUM_PORTS  (NUM_PORTS),
         .NUM_MASTERS(NUM_MASTERS),
         .NUM_CPU    (NUM_CPU),
         .ADDR_W     (ADDR_W),
         .PAGE_W     (PAGE_W),
         .MID_W      (MID_W),
         .PID_W      (PID_W)
      ) u_rgn (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_start  (cfg_we && cfg_idx == CFG_AW'(r*4 + 0)),
         .wr_end    (cfg_we && cfg_idx == CFG_AW'(r*4 + 1)),
         .wr_perm   (cfg_we && cfg_idx == CFG_AW'(r*4 + 2)),
         .wr_ctrl   (cfg_we && cfg_idx == CFG_AW'(r*4 + 3)),
         .wdata     (cfg_wdata),
         .acc_page  (acc_page),
         .acc_master(acc_master),
         .acc_kind  (acc_kind),
         .acc_sup   (acc_sup),
         .acc_pid   (acc_pid),
         .hit       (reg_hit[r]),
         .rd_start  (reg_rd[r*4 + 0]),
         .rd_end    (reg_rd[r*4 + 1]),
         .rd_perm   (reg_rd[r*4 + 2]),
         .rd_ctrl   (reg_rd[r*4 + 3])
      );
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tr
         assign hit_col[p][r] = reg_hit[r][p];
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_verdict
      assign acc_allow[p] = acc_valid[p] &&  (|hit_col[p]);
      assign acc_err[p]   = acc_valid[p] && !(|hit_col[p]);

      mpu_guard_errlog #(
         .ADDR_W(ADDR_W),
         .MID_W (MID_W),
         .PID_W (PID_W)
      ) u_log (
         .clk      (clk),
         .rst_n    (rst_n),
         .deny     (acc_err[p]),
         .clr      (cfg_we && cfg_idx == CFG_AW'(FLAG_IDX) && cfg_wdata[p]),
         .addr     (acc_addr[p*ADDR_W +: ADDR_W]),
         .master   (acc_master[p*MID_W +: MID_W]),
         .kind     (acc_kind[p*2 +: 2]),
         .sup      (acc_sup[p]),
         .pid      (acc_pid[p*PID_W +: PID_W]),
         .flag     (err_flag[p]),
         .rd_addr  (err_rd_addr[p]),
         .rd_detail(err_rd_det[p])
      );
      assign cap_addr_flat[p*32 +: 32] = err_rd_addr[p];
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < REG_WORDS; i++) begin
         if (cfg_idx == CFG_AW'(i)) cfg_rdata = reg_rd[i];
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (cfg_idx == CFG_AW'(ERR_BASE + 2*p))     cfg_rdata = err_rd_addr[p];
         if (cfg_idx == CFG_AW'(ERR_BASE + 2*p + 1)) cfg_rdata = err_rd_det[p];
      end
      if (cfg_idx == CFG_AW'(FLAG_IDX)) cfg_rdata = 32'(err_flag);
   end

endmodule

// File: rtl/mpu_guard_chk.sv
`timescale 1ns/1ps
module mpu_guard_chk #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CFG_AW    = 6,
   parameter int unsigned FLAG_IDX  = 38
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_we,
   input logic [CFG_AW-1:0]           cfg_idx,
   input logic [31:0]                 cfg_wdata,
   input logic [NUM_PORTS-1:0]        acc_valid,
   input logic [NUM_PORTS*ADDR_W-1:0] acc_addr,
   input logic [NUM_PORTS-1:0]        acc_allow,
   input logic [NUM_PORTS-1:0]        acc_err,
   input logic [NUM_PORTS-1:0]        err_flag,
   input logic [NUM_PORTS*32-1:0]     cap_addr_flat
);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      logic clr;
      assign clr = cfg_we && cfg_idx == CFG_AW'(FLAG_IDX) && cfg_wdata[p];

      // R11
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_valid[p] |-> !acc_allow[p] && !acc_err[p]);

      // R7
      one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid[p] |-> $countones({acc_allow[p], acc_err[p]}) == 1);

      // R9
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         acc_err[p] |=> err_flag[p]);

      // R9
      cap_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         acc_err[p] && !err_flag[p] |=>
            cap_addr_flat[p*32 +: ADDR_W] == $past(acc_addr[p*ADDR_W +: ADDR_W]));

      // R10
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         err_flag[p] && !clr |=> err_flag[p]);

      // R10
      cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         err_flag[p] && !clr |=> $stable(cap_addr_flat[p*32 +: 32]));

      // R10
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr && !acc_err[p] |=> !err_flag[p]);
   end

endmodule

bind mpu_guard mpu_guard_chk #(
   .NUM_PORTS(NUM_PORTS),
   .ADDR_W   (ADDR_W),
   .CFG_AW   (CFG_AW),
   .FLAG_IDX (FLAG_IDX)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_idx      (cfg_idx),
   .cfg_wdata    (cfg_wdata),
   .acc_valid    (acc_valid),
   .acc_addr     (acc_addr),
   .acc_allow    (acc_allow),
   .acc_err      (acc_err),
   .err_flag     (err_flag),
   .cap_addr_flat(cap_addr_flat)
);

// File: tb/sim_mpu_guard.sv
`timescale 1ns/1ps
module sim_mpu_guard;

   localparam int NR = 8;
   localparam int NP = 3;
   localparam int NM = 4;
   localparam int NC = 2;
   localparam int FLAGI = NR*4 + NP*2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_idx = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic [NP-1:0] acc_valid = '0;
   logic [NP*32-1:0] acc_addr = '0;
   logic [NP*2-1:0]  acc_master = '0;
   logic [NP*2-1:0]  acc_kind = '0;
   logic [NP-1:0]    acc_sup = '0;
   logic [NP*8-1:0]  acc_pid = '0;
   logic [NP-1:0]    acc_allow, acc_err;

   mpu_guard u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_master(acc_master), .acc_kind(acc_kind),
      .acc_sup(acc_sup), .acc_pid(acc_pid), .acc_allow(acc_allow),
      .acc_err(acc_err)
   );

   always #2.5 clk = ~clk;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // stimulus per port
   bit        pv [NP];
   bit [31:0] pa [NP];
   bit [1:0]  pm [NP];
   bit [1:0]  pk [NP];
   bit        ps [NP];
   bit [7:0]  pp [NP];

   // reference state
   bit [26:0] rs [NR];
   bit [26:0] re [NR];
   bit [3:0]  rperm [NR][NM];
   bit        rv [NR];
   bit        rpe [NR];
   bit [7:0]  rpid [NR];
   bit        mflag [NP];
   bit [31:0] meaddr [NP];
   bit [31:0] medet [NP];

   function automatic bit m_allow(int p);
      if (!pv[p]) return 1'b0;
      for (int r = 0; r < NR; r++) begin
         bit [3:0] nib;
         bit cpu, ok;
         if (!rv[r]) continue;
         if (pa[p][31:5] < rs[r] || pa[p][31:5] > re[r]) continue;
         if (rpe[r] && pp[p] != rpid[r]) continue;
         nib = rperm[r][pm[p]];
         cpu = (pm[p] < NC);
         ok = 1'b0;
         if (pk[p] == 0) ok = nib[0];
         if (pk[p] == 1) ok = nib[1];
         if (pk[p] == 2) ok = cpu && nib[2];
         if (cpu && nib[3] && !ps[p]) ok = 1'b0;
         if (ok) return 1'b1;
      end
      return 1'b0;
   endfunction

   function automatic bit [31:0] m_reg(int idx);
      bit [31:0] v;
      v = '0;
      if (idx < NR*4) begin
         int r = idx / 4;
         case (idx % 4)
            0: v = {rs[r], 5'b0};
            1: v = {re[r], 5'b0};
            2: for (int m = 0; m < NM; m++) v[m*4 +: 4] = rperm[r][m];
            default: v = {16'b0, rpid[r], 6'b0, rpe[r], rv[r]};
         endcase
      end else if (idx < FLAGI) begin
         int p = (idx - NR*4) / 2;
         v = ((idx - NR*4) % 2 == 0) ? meaddr[p] : medet[p];
      end else if (idx == FLAGI) begin
         for (int p = 0; p < NP; p++) v[p] = mflag[p];
      end
      return v;
   endfunction

   task automatic m_write(int idx, bit [31:0] d);
      if (idx < NR*4) begin
         int r = idx / 4;
         case (idx % 4)
            0: rs[r] = d[31:5];
            1: re[r] = d[31:5];
            2: for (int m = 0; m < NM; m++)
                  rperm[r][m] = (m < NC) ? d[m*4 +: 4] : {2'b00, d[m*4 +: 2]};
            default: begin rv[r] = d[0]; rpe[r] = d[1]; rpid[r] = d[15:8]; end
         endcase
      end
   endtask

   task automatic chk(bit ok, string tag, string what, bit [31:0] act, bit [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      for (int p = 0; p < NP; p++) begin
         pv[p] = 0; pa[p] = 0; pm[p] = 0; pk[p] = 0; ps[p] = 0; pp[p] = 0;
      end
   endtask

   // one clock: drive, compare verdicts, advance model
   task automatic step(string tag);
      bit deny [NP];
      bit clr [NP];
      bit we;
      int widx;
      bit [31:0] wd;
      for (int p = 0; p < NP; p++) begin
         acc_valid[p] = pv[p];
         acc_addr[p*32 +: 32] = pa[p];
         acc_master[p*2 +: 2] = pm[p];
         acc_kind[p*2 +: 2] = pk[p];
         acc_sup[p] = ps[p];
         acc_pid[p*8 +: 8] = pp[p];
      end
      #1;
      for (int p = 0; p < NP; p++) begin
         bit ea = m_allow(p);
         bit ee = pv[p] && !ea;
         chk(acc_allow[p] == ea, tag, $sformatf("port%0d allow", p), 32'(acc_allow[p]), 32'(ea));
         chk(acc_err[p] == ee, tag, $sformatf("port%0d err", p), 32'(acc_err[p]), 32'(ee));
         deny[p] = ee;
         clr[p] = cfg_we && cfg_idx == 6'(FLAGI) && cfg_wdata[p];
      end
      we = cfg_we; widx = int'(cfg_idx); wd = cfg_wdata;
      @(posedge clk);
      for (int p = 0; p < NP; p++) begin
         if (deny[p] && (!mflag[p] || clr[p])) begin
            meaddr[p] = pa[p];
            medet[p] = {8'b0, pp[p], 4'b0, 2'b0, pm[p], 5'b0, ps[p], pk[p]};
         end
         mflag[p] = (mflag[p] && !clr[p]) || deny[p];
      end
      if (we) m_write(widx, wd);
      @(negedge clk);
   endtask

   task automatic wr(int idx, bit [31:0] d, string tag);
      cfg_we = 1'b1; cfg_idx = 6'(idx); cfg_wdata = d;
      step(tag);
      cfg_we = 1'b0;
   endtask

   task automatic rd(int idx, bit [31:0] exp, string tag);
      cfg_idx = 6'(idx);
      #1;
      chk(cfg_rdata == exp, tag, $sformatf("reg[%0d]", idx), cfg_rdata, exp);
   endtask

   task automatic probe(int m, int k, bit s, bit [31:0] a, bit [7:0] pid, string tag);
      idle();
      pv[0] = 1; pm[0] = 2'(m); pk[0] = 2'(k); ps[0] = s; pa[0] = a; pp[0] = pid;
      step(tag);
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      idle();
      for (int r = 0; r < NR; r++) m_write(r*4+3, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(FLAGI, 0, "R1");
      rd(NR*4, 0, "R1");
      rd(3, 0, "R1");
      probe(0, 0, 1, 32'h0000_1000, 0, "R1");
      rd(FLAGI, m_reg(FLAGI), "R1");
      wr(FLAGI, 32'h7, "R10");

      // window 0: pages 0x1000..0x1FFF
      wr(0, 32'h0000_101F, "R2");
      rd(0, 32'h0000_1000, "R2");
      wr(1, 32'h0000_1FE0, "R2");
      wr(2, 32'h0000_05F7, "R5");
      rd(2, 32'h0000_01F7, "R5");
      wr(3, 32'h1, "R12");
      probe(0, 0, 0, 32'h0000_1000, 0, "R2");
      probe(0, 0, 0, 32'h0000_1FFF, 0, "R2");
      probe(0, 0, 0, 32'h0000_0FFF, 0, "R2");
      probe(0, 0, 0, 32'h0000_2000, 0, "R2");
      probe(2, 0, 0, 32'h0000_1100, 0, "R4");
      probe(2, 1, 0, 32'h0000_1100, 0, "R4");
      probe(3, 0, 0, 32'h0000_1100, 0, "R4");
      probe(0, 3, 1, 32'h0000_1100, 0, "R4");
      probe(2, 2, 1, 32'h0000_1100, 0, "R5");
      probe(0, 2, 0, 32'h0000_1100, 0, "R5");
      probe(1, 0, 0, 32'h0000_1100, 0, "R5");
      probe(1, 0, 1, 32'h0000_1100, 0, "R5");

      // window 1 overlaps window 0, write for master 2
      wr(4, 32'h0000_1800, "R3");
      wr(5, 32'h0000_27E0, "R3");
      wr(6, 32'h0000_0200, "R3");
      wr(7, 32'h1, "R3");
      probe(2, 1, 0, 32'h0000_1800, 0, "R3");
      probe(2, 1, 0, 32'h0000_1000, 0, "R3");
      probe(2, 0, 0, 32'h0000_1900, 0, "R3");
      probe(2, 1, 0, 32'h0000_2700, 0, "R3");

      // window 2 with PID qualifier
      wr(8, 32'h0000_8000, "R6");
      wr(9, 32'h0000_8FE0, "R6");
      wr(10, 32'h0000_0001, "R6");
      wr(11, 32'h0000_5A03, "R6");
      probe(0, 0, 0, 32'h0000_8040, 8'h5A, "R6");
      probe(0, 0, 0, 32'h0000_8040, 8'h33, "R6");
      wr(11, 32'h0000_5A01, "R6");
      probe(0, 0, 0, 32'h0000_8040, 8'h33, "R6");
      wr(11, 32'h0, "R7");
      rd(11, 32'h0, "R7");
      probe(0, 0, 0, 32'h0000_8040, 8'h5A, "R7");

      // R8 three ports in one cycle
      idle();
      pv[0] = 1; pm[0] = 0; pk[0] = 0; pa[0] = 32'h1000;
      pv[1] = 1; pm[1] = 2; pk[1] = 1; pa[1] = 32'h1000;
      pv[2] = 1; pm[2] = 1; pk[2] = 2; ps[2] = 1; pa[2] = 32'h1004;
      step("R8");
      idle();

      // R9 / R10 capture behaviour
      wr(FLAGI, 32'h7, "R10");
      rd(FLAGI, 0, "R10");
      idle(); pv[1] = 1; pm[1] = 2; pk[1] = 1; pa[1] = 32'h1234; pp[1] = 8'h33;
      step("R9");
      idle(); step("R9");
      rd(NR*4+2, 32'h0000_1234, "R9");
      rd(NR*4+3, 32'h0033_0201, "R9");
      rd(FLAGI, 32'h2, "R9");
      idle(); pv[1] = 1; pm[1] = 3; pk[1] = 0; pa[1] = 32'h0040;
      step("R10"); idle();
      rd(NR*4+2, 32'h0000_1234, "R10");
      idle(); pv[1] = 1; pm[1] = 3; pk[1] = 0; pa[1] = 32'h0080;
      wr(FLAGI, 32'h2, "R10"); idle();
      rd(NR*4+2, 32'h0000_0080, "R10");
      rd(FLAGI, 32'h2, "R10");
      wr(FLAGI, 32'h2, "R10");
      rd(FLAGI, 32'h0, "R10");

      // R11 idle port ignored
      idle(); pa[0] = 32'h0; pm[0] = 3; pk[0] = 3;
      step("R11");
      rd(FLAGI, 32'h0, "R11");
      rd(NR*4, m_reg(NR*4), "R11");

      // random phase against the model
      for (int c = 0; c < 600; c++) begin
         for (int p = 0; p < NP; p++) begin
            pv[p] = ($urandom_range(0, 3) != 0);
            pa[p] = $urandom & 32'h0000_FFFF;
            pm[p] = 2'($urandom_range(0, 3));
            pk[p] = 2'($urandom_range(0, 3));
            ps[p] = 1'($urandom_range(0, 1));
            pp[p] = ($urandom_range(0, 1) != 0) ? 8'h5A : 8'h33;
         end
         if ($urandom_range(0, 5) == 0) begin
            int idx = $urandom_range(0, FLAGI);
            bit [31:0] d = $urandom;
            if (idx < NR*4 && idx % 4 < 2) d = d & 32'h0000_FFFF;
            if (idx < NR*4 && idx % 4 == 3)
               d = {16'b0, (d[4] ? 8'h5A : 8'h33), 6'b0, d[1], d[0] | d[2]};
            wr(idx, d, "R12");
         end else begin
            step("R8");
         end
         if (c % 8 == 7) begin
            for (int i = NR*4; i <= FLAGI; i++) rd(i, m_reg(i), "R9");
            begin
               int j = $urandom_range(0, NR*4-1);
               rd(j, m_reg(j), "R12");
            end
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule